// File: doc/BRIEF.md
# Light Sensor I2C Register Slave

This block is the serial host port of an ambient-light measurement controller. It watches SCL and SDA, which arrive already synchronized to the system clock and are sampled at many clocks per bus bit. It pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit. Behind the port sits a small map of byte-wide registers. A command byte and a gain byte configure the measurement core. Four read-only bytes return the latest 16-bit light result and the 16-bit timer count that goes with it.

A host writes by sending the device address, a register pointer and one or more data bytes. It reads by sending the address and the pointer, then a repeated start, the address with the read bit set, and collecting bytes. A pointer byte with either of its two top bits set is also a command. Bit 7 fires a one-cycle conversion-sync pulse and bit 6 fires a one-cycle interrupt-clear pulse toward the measurement core. The sensor and timer inputs are plain levels that are sampled when read, so no back-pressure applies on them.

Top module: `lsi_i2c_regslave`

## Requirements
- R1: The slave answers only to the 7-bit address formed by 100010 followed by the level of `addr_sel_i`. For any other address it keeps `sda_oe_o` low for the rest of that transaction.
- R2: The command byte sits at pointer 00h and resets to 00h. Writes store all bits except bit 4, which always reads 0. The whole byte is driven on `cmd_o`.
- R3: The gain byte sits at pointer 01h and resets to 00h. Only bits 3:2 are stored, and they are driven on `gain_o`. A read returns them in bits 3:2 with every other bit 0.
- R4: Pointers 04h and 05h read the low and high bytes of `sensor_i`. Pointers 06h and 07h read the low and high bytes of `timer_i`.
- R5: Reading 04h (or 06h) captures the whole 16-bit value. A later read of 05h (or 07h) returns the high byte of that capture, even if the input has changed since, and returns 00h if no capture has been taken since reset.
- R6: A pointer byte with bit 7 set produces exactly one single-cycle pulse on `sync_pulse_o`. No stored register changes.
- R7: A pointer byte with bit 6 set produces exactly one single-cycle pulse on `intclr_pulse_o`. No stored register changes.
- R8: Writes to 02h-07h or to any pointer with bits 7:3 non-zero are acknowledged and discarded. Reads from unmapped pointers return 00h. Configuration holds its value until it is written again.
- R9: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The slave drives the acknowledge low during the ninth clock after a matching address, the pointer and each written byte. A read after a repeated start uses the stored pointer.
- R10: When the master answers a read byte with NAK (SDA high in the ninth clock), the slave drives SDA no further until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | Least-significant address bit |
| sensor_i | input | 16 | Latest light result |
| timer_i | input | 16 | Timer count of that result |
| cmd_o | output | 8 | Command byte |
| gain_o | output | 2 | Gain/range select |
| sync_pulse_o | output | 1 | One-cycle conversion-sync strobe |
| intclr_pulse_o | output | 1 | One-cycle interrupt-clear strobe |

## Verification
The checks assume a single well-behaved master. SDA changes only while SCL is low, except for START and STOP. Each SCL high and low phase lasts several system clocks, so every edge is seen as a distinct sampled transition. The bench master drives SCL and SDA in quarter-bit steps of five clocks and changes SDA only in the middle of the low phase. It resolves the bus as the master level ANDed with the inverse of the slave's enable, so slave drive and master drive never contradict during START or STOP.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  localparam int BYTE_W = 8;
  localparam int RES_W  = 16;
  localparam int CNT_W  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } lsi_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

  localparam logic [2:0] REG_CMD    = 3'd0;
  localparam logic [2:0] REG_GAIN   = 3'd1;
  localparam logic [2:0] REG_SNS_LO = 3'd4;
  localparam logic [2:0] REG_SNS_HI = 3'd5;
  localparam logic [2:0] REG_TMR_LO = 3'd6;
  localparam logic [2:0] REG_TMR_HI = 3'd7;
endpackage

// File: rtl/lsi_bus_events.sv
module lsi_bus_events
  import lsi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
    ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
    ev_o.rise  = scl_i & ~scl_q;
    ev_o.fall  = ~scl_i & scl_q;
  end
endmodule

// File: rtl/lsi_link_fsm.sv
module lsi_link_fsm
  import lsi_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              sda_oe_o,
  output logic              sync_o,
  output logic              clr_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  lsi_state_e        st_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ptr_q;
  logic              rw_q, mack_q, oe_q;
  logic              wr_q, sync_q, clr_q;
  logic              frame_ev, addr_hit;

  assign frame_ev = ev_i.start | ev_i.stop;
  assign addr_hit = (rx_q[BYTE_W-1:1] == {ADDR_HI, addr_sel_i});

  // A byte is fetched from the register bank at the SCL fall that opens a read byte.
  assign rd_req_o = ~frame_ev & ev_i.fall &
                    (((st_q == ST_ADDR_ACK) & rw_q) | ((st_q == ST_RD_ACK) & mack_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      sync_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      sync_q <= 1'b0;
      clr_q  <= 1'b0;
      if (ev_i.stop) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (ev_i.start) begin
        st_q  <= ST_ADDR;
        bit_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (ev_i.rise) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_i};
              bit_q <= bit_q + 1'b1;
            end else if (ev_i.fall && bit_q == LAST_BIT) begin
              if (st_q == ST_ADDR) begin
                if (addr_hit) begin
                  oe_q <= 1'b1;
                  rw_q <= rx_q[0];
                  st_q <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_SKIP;
                end
              end else if (st_q == ST_PTR) begin
                oe_q   <= 1'b1;
                ptr_q  <= rx_q;
                sync_q <= rx_q[BYTE_W-1];
                clr_q  <= rx_q[BYTE_W-2];
                st_q   <= ST_PTR_ACK;
              end else begin
                oe_q <= 1'b1;
                wr_q <= 1'b1;
                st_q <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev_i.fall) begin
              bit_q <= '0;
              if (rw_q) begin
                tx_q <= rd_data_i;
                oe_q <= ~rd_data_i[BYTE_W-1];
                st_q <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WR_ACK: begin
            if (ev_i.fall) begin
              bit_q <= '0;
              oe_q  <= 1'b0;
              st_q  <= ST_WR;
            end
          end
          ST_RD: begin
            if (ev_i.rise) begin
              bit_q <= bit_q + 1'b1;
            end else if (ev_i.fall) begin
              if (bit_q == LAST_BIT) begin
                oe_q <= 1'b0;
                st_q <= ST_RD_ACK;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (ev_i.rise) begin
              mack_q <= ~sda_i;
            end else if (ev_i.fall) begin
              bit_q <= '0;
              if (mack_q) begin
                tx_q <= rd_data_i;
                oe_q <= ~rd_data_i[BYTE_W-1];
                st_q <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_SKIP;
              end
            end
          end
          default: oe_q <= 1'b0;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign wr_data_o = rx_q;
  assign ptr_o     = ptr_q;
  assign sda_oe_o  = oe_q;
  assign sync_o    = sync_q;
  assign clr_o     = clr_q;
endmodule

// File: rtl/lsi_regbank.sv
module lsi_regbank
  import lsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] ptr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic [RES_W-1:0]  sensor_i,
  input  logic [RES_W-1:0]  timer_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [1:0]        gain_o
);
  localparam int N_RES = 2;
  localparam logic [BYTE_W-1:0] CMD_MASK = 8'hEF;

  logic [RES_W-1:0] live   [N_RES];
  logic [RES_W-1:0] snap_q [N_RES];
  logic             mapped;
  logic [2:0]       idx;
  logic [BYTE_W-1:0] cmd_q;
  logic [1:0]        gain_q;

  assign mapped  = (ptr_i[BYTE_W-1:3] == '0);
  assign idx     = ptr_i[2:0];
  assign live[0] = sensor_i;
  assign live[1] = timer_i;

  for (genvar c = 0; c < N_RES; c++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        snap_q[c] <= '0;
      else if (rd_req_i && mapped && idx[2] && !idx[0] && (idx[1] == c[0]))
        snap_q[c] <= live[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      gain_q <= '0;
    end else if (wr_en_i && mapped) begin
      if (idx == REG_CMD)  cmd_q  <= wr_data_i & CMD_MASK;
      if (idx == REG_GAIN) gain_q <= wr_data_i[3:2];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (mapped) begin
      unique case (idx)
        REG_CMD:    rd_data_o = cmd_q;
        REG_GAIN:   rd_data_o = {4'b0000, gain_q, 2'b00};
        REG_SNS_LO: rd_data_o = live[0][BYTE_W-1:0];
        REG_SNS_HI: rd_data_o = snap_q[0][RES_W-1:BYTE_W];
        REG_TMR_LO: rd_data_o = live[1][BYTE_W-1:0];
        REG_TMR_HI: rd_data_o = snap_q[1][RES_W-1:BYTE_W];
        default:    rd_data_o = '0;
      endcase
    end
  end

  assign cmd_o  = cmd_q;
  assign gain_o = gain_q;
endmodule

// File: rtl/lsi_i2c_regslave.sv
module lsi_i2c_regslave
  import lsi_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  input  logic [RES_W-1:0]  sensor_i,
  input  logic [RES_W-1:0]  timer_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic [1:0]        gain_o,
  output logic              sync_pulse_o,
  output logic              intclr_pulse_o
);
  bus_ev_t           ev;
  logic              rd_req, wr_en;
  logic [BYTE_W-1:0] rd_data, wr_data, ptr;

  lsi_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
  );

  lsi_link_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .sda_i(sda_i),
    .addr_sel_i(addr_sel_i), .rd_data_i(rd_data), .rd_req_o(rd_req),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .ptr_o(ptr),
    .sda_oe_o(sda_oe_o), .sync_o(sync_pulse_o), .clr_o(intclr_pulse_o)
  );

  lsi_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .ptr_i(ptr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_req_i(rd_req), .sensor_i(sensor_i),
    .timer_i(timer_i), .rd_data_o(rd_data), .cmd_o(cmd_o), .gain_o(gain_o)
  );
endmodule

// File: rtl/lsi_i2c_regslave_chk.sv
module lsi_i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe_o,
  input logic [7:0] cmd_o,
  input logic [1:0] gain_o,
  input logic       sync_pulse_o,
  input logic       intclr_pulse_o
);
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe_o);

  // R9
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

  // R6
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse_o |=> !sync_pulse_o);

  // R7
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intclr_pulse_o |=> !intclr_pulse_o);

  // R2
  cmd_bit4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_o[4]);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> ($stable(cmd_o) && $stable(gain_o)));

  // R6
  sync_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse_o || intclr_pulse_o) |-> !scl_i);
endmodule

bind lsi_i2c_regslave lsi_i2c_regslave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .cmd_o(cmd_o), .gain_o(gain_o),
  .sync_pulse_o(sync_pulse_o), .intclr_pulse_o(intclr_pulse_o)
);

// File: tb/lsi_i2c_regslave_tb_top.sv
module lsi_i2c_regslave_tb_top;
  localparam int Q = 5;
  localparam int NVEC = 8;
  // {pointer, write data, expected read-back}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'hA5, 8'hA5}, {8'h00, 8'hFF, 8'hEF}, {8'h01, 8'hFF, 8'h0C},
    {8'h01, 8'h04, 8'h04}, {8'h02, 8'h77, 8'h00}, {8'h03, 8'hFF, 8'h00},
    {8'h00, 8'h3A, 8'h2A}, {8'h05, 8'h99, 8'h00}
  };
  localparam string TAG [NVEC] = '{"R2", "R2", "R3", "R3", "R8", "R8", "R2", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [15:0] sensor = 16'h1234, timer = 16'h5678;
  logic sda_oe, sync_p, clr_p;
  logic [7:0] cmd;
  logic [1:0] gain;
  logic sda_bus;
  int n_vec = 0, n_bad = 0, n_sync = 0, n_clr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  lsi_i2c_regslave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .sensor_i(sensor),
    .timer_i(timer), .cmd_o(cmd), .gain_o(gain),
    .sync_pulse_o(sync_p), .intclr_pulse_o(clr_p)
  );

  always @(negedge clk) begin
    if (sync_p) n_sync++;
    if (clr_p)  n_clr++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack_n = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic nak, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(); scl_m = 1'b1; qw(); d = {d[6:0], sda_bus}; qw(); scl_m = 1'b0; qw();
    end
    sda_m = nak; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b100010, addr_sel, rd};
  endfunction

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte(dev(1'b0), acks[2]);
    send_byte(p, acks[1]);
    send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte(dev(1'b0), a);
    send_byte(p, a);
    bus_start();
    send_byte(dev(1'b1), a);
    recv_byte(1'b1, d);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [2:0] acks;
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R2 R3 reset state
    chk("R2", {8'h0, cmd}, 16'h0000);
    chk("R3", {14'h0, gain}, 16'h0000);
    chk("R9", {15'h0, sda_oe | sync_p | clr_p}, 16'h0000);

    for (int v = 0; v < NVEC; v++) begin
      write_reg(VEC[v][23:16], VEC[v][15:8], acks);
      read_reg(VEC[v][23:16], d);
      chk(TAG[v], {5'h0, acks, d}, {8'h00, VEC[v][7:0]});
    end
    // R8 configuration held at ports
    chk("R8", {6'h0, gain, cmd}, {6'h0, 2'b01, 8'h2A});

    // R10 NAK after a read releases SDA (cmd bit7 = 0 would be driven low)
    bus_start(); send_byte(dev(1'b0), a); send_byte(8'h00, a);
    bus_start(); send_byte(dev(1'b1), a); recv_byte(1'b1, d);
    qw();
    chk("R10", {7'h0, sda_oe, d}, {8'h00, 8'h2A});
    bus_stop();

    // R6 sync strobe from pointer bit 7, no data byte
    bus_start(); send_byte(dev(1'b0), a); send_byte(8'h80, acks[0]); bus_stop();
    chk("R6", {n_sync[3:0], n_clr[3:0], 7'h0, acks[0]}, {4'd1, 4'd0, 8'h00});
    // R7 interrupt-clear strobe from pointer bit 6
    bus_start(); send_byte(dev(1'b0), a); send_byte(8'h40, a); bus_stop();
    chk("R7", {n_sync[3:0], n_clr[3:0], 8'h0}, {4'd1, 4'd1, 8'h00});
    // R6 R7 both strobes plus discarded data
    write_reg(8'hC0, 8'h11, acks);
    chk("R6", {n_sync[3:0], n_clr[3:0], cmd}, {4'd2, 4'd2, 8'h2A});
    chk("R9", {13'h0, acks}, 16'h0000);

    // R1 foreign address gets no acknowledge and writes nothing
    bus_start(); send_byte(8'h8C, acks[2]); send_byte(8'h00, acks[1]);
    send_byte(8'hFF, acks[0]); bus_stop();
    chk("R1", {5'h0, acks, cmd}, {5'h0, 3'b111, 8'h2A});

    // R1 address-select pin
    addr_sel = 1'b1;
    write_reg(8'h00, 8'h81, acks);
    chk("R1", {5'h0, acks, cmd}, {5'h0, 3'b000, 8'h81});
    bus_start(); send_byte(8'h88, a); bus_stop();
    chk("R1", {15'h0, a}, 16'h0001);
    addr_sel = 1'b0;

    // R4 R5 snapshot of sensor and timer
    read_reg(8'h04, d);
    chk("R4", {8'h0, d}, 16'h0034);
    sensor = 16'hABCD;
    read_reg(8'h05, d);
    chk("R5", {8'h0, d}, 16'h0012);
    read_reg(8'h06, d);
    chk("R4", {8'h0, d}, 16'h0078);
    timer = 16'h9ABC;
    read_reg(8'h07, d);
    chk("R5", {8'h0, d}, 16'h0056);
    read_reg(8'h04, d);
    read_reg(8'h05, d);
    chk("R4", {8'h0, d}, 16'h00AB);
    // R8 unmapped pointer reads zero
    read_reg(8'h48, d);
    chk("R8", {8'h0, d}, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule